// File: doc/BRIEF.md
# Shared Gain and Offset Calibration Engine

This block sits between a register write port and the four input registers of a 16-bit, four-channel output converter. Every channel keeps its own 16-bit gain word and 16-bit offset word. When new sample data is written to a channel, the block computes a calibrated code and loads it into that channel's output register. An update strobe for that channel marks the load.

A single multiplier and a single adder do the arithmetic for all channels. Data writes that arrive while the arithmetic unit is working are held as per-channel pending requests. They are then served one at a time. Writing a gain or offset word only stores it. The new value takes effect on the next data write to the same channel. A busy flag tells the writer that work is still outstanding.

Top module: `cal_engine_top`

## Requirements
- R1: The calibrated code is floor(D*(G+1)/65536) + K - 32768, where D is the data word, G is the channel's gain word and K is the channel's offset word.
- R2: After reset every gain word is 65535 and every offset word is 32768, so a data word passes through unchanged.
- R3: Gain and offset words are held per channel. A write to one channel's words does not alter the result computed for another channel.
- R4: A gain write (wr_sel = 1) or an offset write (wr_sel = 0b10) produces no update strobe, leaves every output code unchanged and does not raise busy. The next data write (wr_sel = 0) to that channel uses the new words.
- R5: A result below 0 is clamped to 0, and a result above 65535 is clamped to 65535.
- R6: Pending channels are served lowest index first. Each calculation holds the arithmetic unit for CALC_CYC cycles before the next channel is started.
- R7: A data write to a channel whose request is still pending replaces the queued data word. That channel then produces exactly one update, carrying the latest value.
- R8: busy is high from the cycle after a data write until the last pending result has been loaded into its output register.
- R9: A write with wr_sel = 3 is ignored. It produces no strobe, does not raise busy and changes no stored word.
- R10: Reset clears every output code to 0 and every strobe to 0. At most one update strobe is high in any cycle, and an output code changes only in a cycle in which its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_ch | input | 2 | Target channel |
| wr_sel | input | 2 | 0 data, 1 gain, 2 offset, 3 no operation |
| wr_data | input | 16 | Write data |
| dac_code | output | 4x16 | Calibrated code per channel |
| dac_upd | output | 4 | One-cycle strobe when a channel's code is loaded |
| busy | output | 1 | Requests pending or a calculation in progress |

## Verification
The arithmetic is tried with the reset words, with a half-scale gain plus a positive offset, and with extreme words that push the result past both ends of the range. Together these separate a correct scaling from a pass-through, a wrong rounding and a missing clamp. Back-to-back data writes to all four channels are issued in descending order while the unit is busy, which shows whether service follows index order or arrival order. A repeated write to a waiting channel shows whether queued data is replaced or duplicated. Parameter writes and no-operation writes, each followed by a quiet interval, show whether anything updates early or changes state when it should not.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int CHW = $clog2(NCH);

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_GAIN = 2'd1,
        SEL_OFFS = 2'd2,
        SEL_NOP  = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] gain;
        logic [DW-1:0] offs;
    } operands_t;

    // scale by (gain+1)/2^16, add offset minus mid-scale, clamp
    function automatic logic [DW-1:0] calib(input operands_t op);
        logic [2*DW:0]          prod;
        logic signed [DW+2:0]   sum;
        prod = (2*DW+1)'(op.data) * ((2*DW+1)'(op.gain) + (2*DW+1)'(1));
        sum  = $signed({3'b000, prod[2*DW-1:DW]}) + $signed({3'b000, op.offs})
             - $signed((DW+3)'(1 << (DW-1)));
        if (sum < 0)
            return '0;
        else if (sum > $signed((DW+3)'((1 << DW) - 1)))
            return '1;
        else
            return sum[DW-1:0];
    endfunction
endpackage

// File: rtl/cal_regs.sv
module cal_regs
    import cal_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CHW-1:0]           wr_ch,
    input  logic [1:0]               wr_sel,
    input  logic [DW-1:0]            wr_data,
    input  logic                     launch,
    input  logic [CHW-1:0]           launch_ch,
    output logic [NCH-1:0]           pend,
    output operands_t                launch_op
);
    logic [NCH-1:0][DW-1:0] gain_q;
    logic [NCH-1:0][DW-1:0] offs_q;
    logic [NCH-1:0][DW-1:0] data_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CHW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                gain_q[i] <= '1;
                offs_q[i] <= DW'(1 << (DW-1));
                data_q[i] <= '0;
                pend[i]   <= 1'b0;
            end else begin
                if (hit && wr_sel == SEL_GAIN) gain_q[i] <= wr_data;
                if (hit && wr_sel == SEL_OFFS) offs_q[i] <= wr_data;
                if (hit && wr_sel == SEL_DATA) begin
                    data_q[i] <= wr_data;
                    pend[i]   <= 1'b1;
                end else if (launch && launch_ch == CHW'(i)) begin
                    pend[i]   <= 1'b0;
                end
            end
        end
    end

    assign launch_op.data = data_q[launch_ch];
    assign launch_op.gain = gain_q[launch_ch];
    assign launch_op.offs = offs_q[launch_ch];

    // R9
    sel_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NOP && !launch) |=> $stable(pend));
endmodule

// File: rtl/cal_arb.sv
module cal_arb
    import cal_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] pick
);
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) pick = CHW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
#(
    parameter int CALC_CYC = 3
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CHW-1:0] start_ch,
    input  operands_t      start_op,
    output logic           active,
    output logic           done,
    output logic [CHW-1:0] done_ch,
    output logic [DW-1:0]  result
);
    localparam int CW = $clog2(CALC_CYC + 1);

    logic [CW-1:0]  cnt;
    logic [CHW-1:0] ch_q;
    operands_t      op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
            ch_q    <= '0;
            op_q    <= '0;
            done_ch <= '0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            if (!active && start) begin
                active <= 1'b1;
                cnt    <= CW'(CALC_CYC - 1);
                ch_q   <= start_ch;
                op_q   <= start_op;
            end else if (active) begin
                if (cnt == '0) begin
                    active  <= 1'b0;
                    done    <= 1'b1;
                    done_ch <= ch_q;
                    result  <= calib(op_q);
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    // R6
    done_after_work_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active));
endmodule

// File: rtl/cal_engine_top.sv
module cal_engine_top
    import cal_pkg::*;
#(
    parameter int CALC_CYC = 3
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [CHW-1:0]          wr_ch,
    input  logic [1:0]              wr_sel,
    input  logic [DW-1:0]           wr_data,
    output logic [NCH-1:0][DW-1:0]  dac_code,
    output logic [NCH-1:0]          dac_upd,
    output logic                    busy
);
    logic [NCH-1:0] pend;
    logic           any_pend;
    logic [CHW-1:0] pick;
    logic           active;
    logic           start;
    logic           done;
    logic [CHW-1:0] done_ch;
    logic [DW-1:0]  result;
    operands_t      op;

    assign start = any_pend && !active;

    cal_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
        .launch(start), .launch_ch(pick),
        .pend(pend), .launch_op(op)
    );

    cal_arb u_arb (.req(pend), .any(any_pend), .pick(pick));

    cal_core #(.CALC_CYC(CALC_CYC)) u_core (
        .clk(clk), .rst(rst),
        .start(start), .start_ch(pick), .start_op(op),
        .active(active), .done(done), .done_ch(done_ch), .result(result)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                dac_code[i] <= '0;
                dac_upd[i]  <= 1'b0;
            end else begin
                dac_upd[i] <= done && (done_ch == CHW'(i));
                if (done && done_ch == CHW'(i)) dac_code[i] <= result;
            end
        end

        // R10
        code_change_chk: assert property (@(posedge clk) disable iff (rst)
            (dac_code[i] != $past(dac_code[i])) |-> dac_upd[i]);
    end

    assign busy = any_pend || active || done;

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dac_upd));

    // R8
    busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_DATA) |=> busy);
endmodule

// File: tb/tb_cal_engine_top.sv
module tb_cal_engine_top;
    import cal_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   wr_en = 1'b0;
    logic [CHW-1:0]         wr_ch = '0;
    logic [1:0]             wr_sel = '0;
    logic [DW-1:0]          wr_data = '0;
    logic [NCH-1:0][DW-1:0] dac_code;
    logic [NCH-1:0]         dac_upd;
    logic                   busy;

    int total = 0;
    int bad = 0;
    int    q_ch[$];
    int    q_code[$];
    string q_req[$];
    int    gm[NCH];
    int    om[NCH];

    always #2.5 clk = ~clk;

    cal_engine_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .dac_code(dac_code), .dac_upd(dac_upd), .busy(busy)
    );

    function automatic int expect_code(int d, int g, int k);
        longint v;
        v = (longint'(d) * (longint'(g) + 1)) / 65536 + k - 32768;
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return int'(v);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int ch, int sel, int data);
        wr_en = 1'b1; wr_ch = CHW'(ch); wr_sel = 2'(sel); wr_data = DW'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 1) gm[ch] = data;
        if (sel == 2) om[ch] = data;
    endtask

    task automatic push(int ch, int d, string req);
        q_ch.push_back(ch);
        q_code.push_back(expect_code(d, gm[ch], om[ch]));
        q_req.push_back(req);
    endtask

    task automatic drain();
        for (int n = 0; n < 200 && (busy || q_ch.size() != 0); n++) @(negedge clk);
        @(negedge clk);
        check("R8 idle after drain", int'(busy), 0);
        check("R6 queue empty", q_ch.size(), 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NCH; i++) begin
                if (dac_upd[i]) begin
                    if (q_ch.size() == 0) begin
                        check("R4 unexpected strobe on channel", i, -1);
                    end else begin
                        check({q_req[0], " channel"}, i, q_ch[0]);
                        check({q_req[0], " code"}, int'(dac_code[i]), q_code[0]);
                        void'(q_ch.pop_front());
                        void'(q_code.pop_front());
                        void'(q_req.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin gm[i] = 65535; om[i] = 32768; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        for (int i = 0; i < NCH; i++) check("R10 reset code", int'(dac_code[i]), 0);
        check("R10 reset strobes", int'(dac_upd), 0);
        check("R8 reset busy", int'(busy), 0);

        // R2 default pass-through, R8 busy
        push(0, 16'h1234, "R2");
        wr(0, 0, 16'h1234);
        check("R8 busy after write", int'(busy), 1);
        drain();
        check("R2 passthrough", int'(dac_code[0]), 16'h1234);

        // R4 deferred parameter write, R1 arithmetic
        wr(1, 1, 16'h7FFF);
        wr(1, 2, 32868);
        repeat (8) begin
            check("R4 no busy after param write", int'(busy), 0);
            @(negedge clk);
        end
        check("R4 code unchanged", int'(dac_code[1]), 0);
        push(1, 40000, "R1");
        wr(1, 0, 40000);
        drain();
        check("R1 scaled code", int'(dac_code[1]), 20100);

        // R3 channel 0 still pass-through
        push(0, 500, "R3");
        wr(0, 0, 500);
        drain();

        // R5 clamp high and low
        wr(2, 2, 65535);
        push(2, 65535, "R5 high");
        wr(2, 0, 65535);
        drain();
        wr(3, 2, 0);
        push(3, 10, "R5 low");
        wr(3, 0, 10);
        drain();
        check("R5 low code", int'(dac_code[3]), 0);

        // R9 no-op select
        wr(0, 3, 16'h0001);
        repeat (6) begin
            check("R9 no busy", int'(busy), 0);
            @(negedge clk);
        end
        push(0, 777, "R9");
        wr(0, 0, 777);
        drain();

        // R6 order: ch3 occupies unit, then 2,1,0 queued -> served 0,1,2
        push(3, 4000, "R6");
        push(0, 111, "R6");
        push(1, 30000, "R6");
        push(2, 222, "R6");
        wr(3, 0, 4000);
        wr(2, 0, 222);
        wr(1, 0, 30000);
        wr(0, 0, 111);
        drain();

        // R7 replacement while waiting
        push(2, 1000, "R7");
        push(1, 9000, "R7");
        wr(2, 0, 1000);
        wr(1, 0, 5000);
        wr(1, 0, 9000);
        drain();
        check("R7 final code", int'(dac_code[1]), expect_code(9000, gm[1], om[1]));

        finish_run();
    end
endmodule